// File: doc/BRIEF.md
# Reference Clock Divider Cascade

This block divides a crystal-rate clock down to the comparison frequency of a frequency synthesiser loop. It is a chain of five counting stages. Each stage has a ratio that is fixed or picked by select inputs. The overall ratio then covers two crystal rates (12.8 MHz and 14.4 MHz) and four channel spacings (10, 12.5, 20 and 25 kHz). A final optional stage adds a further ratio of 2, 3 or 4 for a frequency multiplier placed after the chip.

A fixed 200 kHz rate is tapped after the second stage to time a demodulator. Every stage output is a one-cycle enable pulse in the input clock domain, and no derived clocks are made. The chain runs whenever its enable is high, so the demodulator keeps its timing while the rest of the synthesiser is powered down. A new select value takes effect only when the affected stage next wraps. This means a change never cuts a period short.

Top module: `refdiv_chain`

## Requirements
- R1: While rst_ni is low, and while en_i stays low after reset, demod_tick_o and cmp_tick_o are 0.
- R2: The second stage divides by 8 when stg2_sel_i=0 and by 9 when stg2_sel_i=1. With en_i held high, demod_tick_o pulses every 64 or 72 cycles respectively.
- R3: The third stage divides by 4 when stg3_sel_i=0 and by 5 when stg3_sel_i=1.
- R4: The fourth stage divides by 2 when stg4_sel_i=0 and by 4 when stg4_sel_i=1.
- R5: The fifth stage uses stg5_sel_i as a 2-bit code: 0 bypasses the stage (ratio 1), 1 divides by 2, 2 divides by 3 and 3 divides by 4.
- R6: With en_i held high, cmp_tick_o pulses every 8 x R2 x R3 x R4 x R5 cycles. This gives 512, 576, 640, 720, 1024, 1152, 1280 and 1440 for the eight codes of the first three selects when stg5_sel_i=0.
- R7: Suppose en_i is sampled high for the first time at clock edge 0 after a low period. Then the first demod_tick_o pulse is visible after edge 8 x R2 − 1, and the first cmp_tick_o pulse is visible after edge N − 1, where N is the total ratio.
- R8: While en_i is low, no pulse appears one cycle after en_i is sampled low. Every stage is re-armed to its current selection, so re-enabling restarts the phase as in R7.
- R9: A select change takes effect only at the next wrap of its stage. When stg2_sel_i changes right after a demod_tick_o pulse, the next interval uses the old ratio and the following interval uses the new one.
- R10: Every pulse lasts one cycle, and every cmp_tick_o pulse coincides with a demod_tick_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Crystal-rate reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable for the whole cascade |
| stg2_sel_i | input | 1 | Second stage: 0 = /8, 1 = /9 |
| stg3_sel_i | input | 1 | Third stage: 0 = /4, 1 = /5 |
| stg4_sel_i | input | 1 | Fourth stage: 0 = /2, 1 = /4 |
| stg5_sel_i | input | 2 | Fifth stage: 0 bypass, 1 = /2, 2 = /3, 3 = /4 |
| demod_tick_o | output | 1 | One-cycle pulse at the demodulator rate (after stage 2) |
| cmp_tick_o | output | 1 | One-cycle pulse at the comparison rate |

## Verification
The bench builds the block with its default 4-bit stage counters and the demodulator tap after stage 2. These settings cover every stage ratio from the bypass value 1 up to 9, and every total from 512 up to the largest, 5760. All eight crystal and spacing codes run with the fifth stage bypassed. Random codes then drive the fifth stage and the mixed combinations. A mid-run change of the second-stage select shows whether the old ratio is kept until the wrap.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;
  localparam int NUM_STG   = 5;
  localparam int STG_W     = 4;
  localparam int DEMOD_TAP = 2;
  localparam int FIRST_DIV = 8;

  typedef logic [STG_W-1:0] ratio_t;

  function automatic ratio_t stg_ratio(int idx, logic s2, logic s3, logic s4, logic [1:0] s5);
    ratio_t r;
    case (idx)
      0:       r = ratio_t'(FIRST_DIV);
      1:       r = s2 ? ratio_t'(9) : ratio_t'(8);
      2:       r = s3 ? ratio_t'(5) : ratio_t'(4);
      3:       r = s4 ? ratio_t'(4) : ratio_t'(2);
      default: r = ratio_t'(s5) + ratio_t'(1);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/refdiv_ratio_dec.sv
module refdiv_ratio_dec
  import refdiv_pkg::*;
#(
  parameter int N_STG = NUM_STG,
  parameter int CNT_W = STG_W
) (
  input  logic                        stg2_sel_i,
  input  logic                        stg3_sel_i,
  input  logic                        stg4_sel_i,
  input  logic [1:0]                  stg5_sel_i,
  output logic [N_STG-1:0][CNT_W-1:0] ratio_o
);
  for (genvar g = 0; g < N_STG; g++) begin : g_dec
    always_comb ratio_o[g] = CNT_W'(stg_ratio(g, stg2_sel_i, stg3_sel_i, stg4_sel_i, stg5_sel_i));
  end
endmodule

// File: rtl/refdiv_stage.sv
module refdiv_stage #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap   = tick_i && (cnt_q == '0);
  assign tick_o = wrap;

  // ratio sampled only on re-arm or wrap: no runt periods
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= ratio_i - CNT_W'(1);
    else if (wrap)    cnt_q <= ratio_i - CNT_W'(1);
    else if (tick_i)  cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/refdiv_chain.sv
module refdiv_chain
  import refdiv_pkg::*;
#(
  parameter int N_STG = NUM_STG,
  parameter int CNT_W = STG_W,
  parameter int TAP   = DEMOD_TAP
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       stg2_sel_i,
  input  logic       stg3_sel_i,
  input  logic       stg4_sel_i,
  input  logic [1:0] stg5_sel_i,
  output logic       demod_tick_o,
  output logic       cmp_tick_o
);
  logic [N_STG-1:0][CNT_W-1:0] ratio;
  logic [N_STG:0]              tick;
  logic                        demod_q, cmp_q;

  refdiv_ratio_dec #(.N_STG(N_STG), .CNT_W(CNT_W)) u_dec (
    .stg2_sel_i (stg2_sel_i),
    .stg3_sel_i (stg3_sel_i),
    .stg4_sel_i (stg4_sel_i),
    .stg5_sel_i (stg5_sel_i),
    .ratio_o    (ratio)
  );

  assign tick[0] = en_i;

  for (genvar g = 0; g < N_STG; g++) begin : g_stg
    refdiv_stage #(.CNT_W(CNT_W)) u_stg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i),
      .tick_i  (tick[g]),
      .ratio_i (ratio[g]),
      .tick_o  (tick[g+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      demod_q <= 1'b0;
      cmp_q   <= 1'b0;
    end else begin
      demod_q <= tick[TAP];
      cmp_q   <= tick[N_STG];
    end
  end

  assign demod_tick_o = demod_q;
  assign cmp_tick_o   = cmp_q;
endmodule

// File: rtl/refdiv_chain_chk.sv
module refdiv_chain_chk #(
  parameter int GAP_W   = 13,
  parameter int DEM_LO  = 64,
  parameter int DEM_HI  = 72,
  parameter int CMP_MIN = 512
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic demod_tick_o,
  input logic cmp_tick_o
);
  logic [GAP_W-1:0] dgap_q, cgap_q;
  logic             dval_q, cval_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dgap_q <= '0; cgap_q <= '0; dval_q <= 1'b0; cval_q <= 1'b0;
    end else if (!en_i) begin
      dgap_q <= '0; cgap_q <= '0; dval_q <= 1'b0; cval_q <= 1'b0;
    end else begin
      if (demod_tick_o) begin dgap_q <= GAP_W'(1); dval_q <= 1'b1; end
      else              dgap_q <= dgap_q + GAP_W'(1);
      if (cmp_tick_o)   begin cgap_q <= GAP_W'(1); cval_q <= 1'b1; end
      else              cgap_q <= cgap_q + GAP_W'(1);
    end
  end

  // R8
  quiet_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!demod_tick_o && !cmp_tick_o));

  // R10
  cmp_in_demod_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_tick_o |-> demod_tick_o);

  // R10
  demod_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    demod_tick_o |=> !demod_tick_o);

  // R2
  demod_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (demod_tick_o && dval_q) |-> (dgap_q == GAP_W'(DEM_LO) || dgap_q == GAP_W'(DEM_HI)));

  // R6
  cmp_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_tick_o && cval_q) |-> (cgap_q >= GAP_W'(CMP_MIN)));
endmodule

bind refdiv_chain refdiv_chain_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .en_i         (en_i),
  .demod_tick_o (demod_tick_o),
  .cmp_tick_o   (cmp_tick_o)
);

// File: tb/sim_refdiv_chain.sv
`timescale 1ns/1ps
module sim_refdiv_chain;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic s2 = 1'b0, s3 = 1'b0, s4 = 1'b0;
  logic [1:0] s5 = 2'd0;
  logic demod, cmp;
  int total = 0, bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  refdiv_chain u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .stg2_sel_i(s2), .stg3_sel_i(s3), .stg4_sel_i(s4), .stg5_sel_i(s5),
    .demod_tick_o(demod), .cmp_tick_o(cmp)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      bad = bad + 1; total = total + 1;
      $display("FAIL watchdog R6 act=%0d exp=%0d", cyc, 190000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int f_demod(logic a);
    return 8 * (a ? 9 : 8);
  endfunction

  function automatic int f_total(logic a, logic b, logic c, logic [1:0] d);
    return f_demod(a) * (b ? 5 : 4) * (c ? 4 : 2) * (int'(d) + 1);
  endfunction

  task automatic run_cfg(input logic a, input logic b, input logic c, input logic [1:0] d);
    int n, dp, hits, first_d, first_c, last_d, last_c, nc, bad_d, bad_c, coin;
    n = f_total(a, b, c, d);
    dp = f_demod(a);
    hits = 0; first_d = -1; first_c = -1; last_d = 0; last_c = 0;
    nc = 0; bad_d = 0; bad_c = 0; coin = 0;
    @(negedge clk);
    en = 1'b0; s2 = a; s3 = b; s4 = c; s5 = d;
    repeat (4) begin
      @(negedge clk);
      if (demod || cmp) hits++;
    end
    chk(hits == 0, "R8 pulses while off", hits, 0);
    en = 1'b1;
    for (int i = 1; i <= 3 * n + 2 && nc < 3; i++) begin
      @(negedge clk);
      if (demod) begin
        if (first_d < 0) first_d = i;
        else if (i - last_d != dp) bad_d++;
        last_d = i;
      end
      if (cmp) begin
        if (!demod) coin++;
        if (first_c < 0) first_c = i;
        else if (i - last_c != n) bad_c++;
        last_c = i;
        nc++;
      end
    end
    chk(first_d == dp, "R7 first demod", first_d, dp);
    chk(first_c == n, "R7 first cmp", first_c, n);
    chk(bad_d == 0, "R2 demod period", bad_d, 0);
    chk(bad_c == 0 && nc == 3, "R6 R3 R4 R5 cmp period", last_c - first_c, 2 * n);
    chk(coin == 0, "R10 cmp without demod", coin, 0);
  endtask

  task automatic sel_change;
    int last, iv1, iv2, i;
    @(negedge clk);
    en = 1'b0; s2 = 1'b0; s3 = 1'b0; s4 = 1'b0; s5 = 2'd0;
    @(negedge clk);
    en = 1'b1;
    i = 0;
    while (!demod && i < 200) begin @(negedge clk); i++; end
    s2 = 1'b1;
    last = 0; iv1 = 0; iv2 = 0;
    for (int k = 1; k <= 200 && iv2 == 0; k++) begin
      @(negedge clk);
      if (demod) begin
        if (iv1 == 0) iv1 = k; else iv2 = k - iv1;
      end
    end
    chk(iv1 == 64, "R9 old ratio kept", iv1, 64);
    chk(iv2 == 72, "R9 new ratio at wrap", iv2, 72);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    chk(!demod && !cmp, "R1 outputs in reset", {demod, cmp}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!demod && !cmp, "R1 outputs idle after reset", {demod, cmp}, 0);
    for (int k = 0; k < 8; k++) run_cfg(k[0], k[1], k[2], 2'd0);
    run_cfg(1'b0, 1'b0, 1'b0, 2'd1);
    run_cfg(1'b1, 1'b1, 1'b1, 2'd3);
    for (int k = 0; k < 4; k++) begin
      logic [4:0] r;
      r = 5'($urandom);
      run_cfg(r[0], r[1], r[2], r[4:3]);
    end
    sel_change();
    en = 1'b0;
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule